// File: doc/BRIEF.md
# External Interrupt Source Conditioner

This block turns a bank of asynchronous interrupt request pins into clean, per-source requests for a downstream priority arbiter. Each pin passes through a synchronizer. The block then applies a programmable polarity and detects either an edge or a level, depending on the source's sense setting. For every source it tracks a pending bit and an in-service bit.

Each source has one 32-bit configuration word. The word holds:
- a mask;
- a polarity and a sense select;
- a priority and a vector, which travel beside the request;
- a read-only activity flag.

Software reaches the words through a plain write strobe and a combinational read port. Words sit at a fixed byte stride. The arbiter side uses two strobes that carry a source index. An acknowledge moves a source from pending to in-service. An end-of-interrupt releases it.

While a source is active, its detection and routing fields are frozen against writes. The mask always remains writable.

Top module: `ext_irq_cond`

## Requirements
- R1: Source n's word is at byte address n*0x20. Any address whose low five bits are not zero, or whose slot number is NUM_SRC or above, reads as zero and ignores writes.
- R2: Word layout (bit 31 is the MSB):
  - mask at bit 31;
  - activity at bit 30 (read-only);
  - polarity at bit 23;
  - sense at bit 22;
  - priority at bits 19:16;
  - vector at bits 15:0.
  
  Every other bit reads as zero.
- R3: After reset each word reads 0x8000_0000: mask set, everything else zero. No request is raised.
- R4: req[n] is 1 exactly when source n is pending and its mask is 0. req_prio and req_vec always carry the source's stored priority and vector fields.
- R5: A pin value first sampled at rising edge k can change the pending bit no earlier than edge k+2. Sampling goes through two synchronizer stages and then one detection register.
- R6: With sense 0 (edge), pending is set on a transition into the asserted state. Polarity 1 selects a rising transition and polarity 0 a falling one. Pending then holds until acknowledged.
- R7: With sense 1 (level), pending follows the asserted level while the source is not in service: high for polarity 1, low for polarity 0. Pending is held clear while in service.
- R8: An acknowledge whose index names a pending source clears its pending bit and sets its in-service bit. An acknowledge to a source that is not pending changes nothing.
- R9: An end-of-interrupt naming a source clears its in-service bit. An edge that arrives while a source is in service sets its pending bit again.
- R10: The activity bit reads 1 exactly when the source is pending or in service.
- R11: While the activity bit is 1, writes leave polarity, sense, priority and vector unchanged. The mask bit is written on every addressed write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_pin | input | NUM_SRC | Asynchronous interrupt request pins |
| cfg_wr | input | 1 | Write strobe for the configuration word at cfg_addr |
| cfg_addr | input | ADDR_W | Byte address of a configuration word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read of the word at cfg_addr |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_idx | input | IDX_W | Source index for the acknowledge |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_idx | input | IDX_W | Source index for the end-of-interrupt |
| req | output | NUM_SRC | Masked pending requests |
| req_prio | output | NUM_SRC*PRIO_W | Priority of each source, source n at slice n |
| req_vec | output | NUM_SRC*VEC_W | Vector of each source, source n at slice n |

## Verification
The bench builds the block with its defaults: twelve sources, a 4-bit priority, a 16-bit vector, two synchronizer stages and a 9-bit address.

The 9-bit address leaves four slots beyond the last source. Unaligned offsets and out-of-range slots can therefore be driven and read back. The 4-bit index lets acknowledges and end-of-interrupts name non-existent sources 12 to 15.

Full-width fields let an all-ones write expose every reserved bit. A behavioural model tracks every source's synchronizer, pending and in-service state. It also catches the interplay of lock, mask, edge re-arm and level hold-off under random traffic.

// File: rtl/eic_pkg.sv
package eic_pkg;
   localparam int WORD_W      = 32;
   localparam int STRIDE_LOG2 = 5;
   localparam int MASK_BIT    = 31;
   localparam int ACT_BIT     = 30;
   localparam int POL_BIT     = 23;
   localparam int SENSE_BIT   = 22;
   localparam int PRIO_LSB    = 16;
   localparam int PRIO_MAX_W  = 4;
   localparam int VEC_LSB     = 0;
   localparam int VEC_MAX_W   = 16;

   typedef enum logic {
      SENSE_EDGE  = 1'b0,
      SENSE_LEVEL = 1'b1
   } sense_e;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("eic_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/eic_src_cfg.sv
module eic_src_cfg
   import eic_pkg::*;
#(
   parameter int PRIO_W = 4,
   parameter int VEC_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              active,
   input  logic              mask_d,
   input  logic              pol_d,
   input  logic              sense_d,
   input  logic [PRIO_W-1:0] prio_d,
   input  logic [VEC_W-1:0]  vec_d,
   output logic              mask_q,
   output logic              pol_q,
   output sense_e            sense_q,
   output logic [PRIO_W-1:0] prio_q,
   output logic [VEC_W-1:0]  vec_q
);
   logic lock_wr;
   assign lock_wr = wr_en & ~active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= 1'b1;
      end else if (wr_en) begin
         mask_q <= mask_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q   <= 1'b0;
         sense_q <= SENSE_EDGE;
         prio_q  <= '0;
         vec_q   <= '0;
      end else if (lock_wr) begin
         pol_q   <= pol_d;
         sense_q <= sense_e'(sense_d);
         prio_q  <= prio_d;
         vec_q   <= vec_d;
      end
   end
endmodule

// File: rtl/eic_src_core.sv
module eic_src_core
   import eic_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   pin,
   input  logic   pol,
   input  sense_e sense,
   input  logic   ack_sel,
   input  logic   eoi_sel,
   output logic   pend_q,
   output logic   insvc_q
);
   logic pin_s, pin_s_d;
   logic now_on, was_on, went_on;
   logic ack_take;
   logic pend_d, insvc_d;

   eic_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin),
      .q     (pin_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_s_d <= 1'b0;
      else        pin_s_d <= pin_s;
   end

   assign now_on   = pol ? pin_s   : ~pin_s;
   assign was_on   = pol ? pin_s_d : ~pin_s_d;
   assign went_on  = now_on & ~was_on;
   assign ack_take = ack_sel & pend_q;

   always_comb begin
      insvc_d = ack_take | (insvc_q & ~eoi_sel);
      unique case (sense)
         SENSE_LEVEL: pend_d = now_on & ~ack_take & ~insvc_q;
         default:     pend_d = (pend_q & ~ack_take) | went_on;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         insvc_q <= 1'b0;
      end else begin
         pend_q  <= pend_d;
         insvc_q <= insvc_d;
      end
   end
endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
   import eic_pkg::*;
#(
   parameter int  NUM_SRC     = 12,
   parameter int  PRIO_W      = 4,
   parameter int  VEC_W       = 16,
   parameter int  SYNC_STAGES = 2,
   parameter int  ADDR_W      = 9,
   localparam int IDX_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_SRC-1:0]        irq_pin,
   input  logic                      cfg_wr,
   input  logic [ADDR_W-1:0]         cfg_addr,
   input  logic [WORD_W-1:0]         cfg_wdata,
   output logic [WORD_W-1:0]         cfg_rdata,
   input  logic                      ack_valid,
   input  logic [IDX_W-1:0]          ack_idx,
   input  logic                      eoi_valid,
   input  logic [IDX_W-1:0]          eoi_idx,
   output logic [NUM_SRC-1:0]        req,
   output logic [NUM_SRC*PRIO_W-1:0] req_prio,
   output logic [NUM_SRC*VEC_W-1:0]  req_vec
);
   localparam int SLOT_W = ADDR_W - STRIDE_LOG2;
   localparam int LOCK_W = 2 + PRIO_W + VEC_W;

   generate
      if (NUM_SRC < 1) begin : g_bad_num
         $error("ext_irq_cond: NUM_SRC must be at least 1");
      end
      if (PRIO_W < 1 || PRIO_W > PRIO_MAX_W) begin : g_bad_prio
         $error("ext_irq_cond: PRIO_W out of range");
      end
      if (VEC_W < 1 || VEC_W > VEC_MAX_W) begin : g_bad_vec
         $error("ext_irq_cond: VEC_W out of range");
      end
      if (SLOT_W < IDX_W) begin : g_bad_addr
         $error("ext_irq_cond: ADDR_W too narrow for NUM_SRC");
      end
   endgenerate

   logic [SLOT_W-1:0]  slot;
   logic               aligned;
   logic [NUM_SRC-1:0] sel;
   logic [NUM_SRC-1:0] pend_q, insvc_q, mask_q, active;
   logic [NUM_SRC*LOCK_W-1:0] lock_q;
   logic [WORD_W-1:0]  word_a [NUM_SRC];
   logic               unused_wd;

   assign slot      = cfg_addr[ADDR_W-1:STRIDE_LOG2];
   assign aligned   = (cfg_addr[STRIDE_LOG2-1:0] == '0);
   assign unused_wd = ^cfg_wdata;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic              pol_q;
      sense_e            sense_q;
      logic [PRIO_W-1:0] prio_q;
      logic [VEC_W-1:0]  vec_q;
      logic              ack_sel, eoi_sel;

      assign sel[i]   = aligned && (slot == SLOT_W'(i));
      assign ack_sel  = ack_valid && (ack_idx == IDX_W'(i));
      assign eoi_sel  = eoi_valid && (eoi_idx == IDX_W'(i));
      assign active[i] = pend_q[i] | insvc_q[i];

      eic_src_cfg #(.PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_cfg (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (cfg_wr & sel[i]),
         .active  (active[i]),
         .mask_d  (cfg_wdata[MASK_BIT]),
         .pol_d   (cfg_wdata[POL_BIT]),
         .sense_d (cfg_wdata[SENSE_BIT]),
         .prio_d  (cfg_wdata[PRIO_LSB +: PRIO_W]),
         .vec_d   (cfg_wdata[VEC_LSB +: VEC_W]),
         .mask_q  (mask_q[i]),
         .pol_q   (pol_q),
         .sense_q (sense_q),
         .prio_q  (prio_q),
         .vec_q   (vec_q)
      );

      eic_src_core #(.SYNC_STAGES(SYNC_STAGES)) u_core (
         .clk     (clk),
         .rst_n   (rst_n),
         .pin     (irq_pin[i]),
         .pol     (pol_q),
         .sense   (sense_q),
         .ack_sel (ack_sel),
         .eoi_sel (eoi_sel),
         .pend_q  (pend_q[i]),
         .insvc_q (insvc_q[i])
      );

      always_comb begin
         word_a[i] = '0;
         word_a[i][MASK_BIT]  = mask_q[i];
         word_a[i][ACT_BIT]   = active[i];
         word_a[i][POL_BIT]   = pol_q;
         word_a[i][SENSE_BIT] = sense_q;
         word_a[i][PRIO_LSB +: PRIO_W] = prio_q;
         word_a[i][VEC_LSB +: VEC_W]   = vec_q;
      end

      assign req[i] = pend_q[i] & ~mask_q[i];
      assign req_prio[i*PRIO_W +: PRIO_W] = prio_q;
      assign req_vec[i*VEC_W +: VEC_W]    = vec_q;
      assign lock_q[i*LOCK_W +: LOCK_W]   = {pol_q, sense_q, prio_q, vec_q};
   end

   always_comb begin
      cfg_rdata = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (sel[i]) cfg_rdata = cfg_rdata | word_a[i];
      end
   end
endmodule

// File: rtl/eic_chk.sv
module eic_chk #(
   parameter int NUM_SRC = 12,
   parameter int IDX_W   = 4,
   parameter int LOCK_W  = 22
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      ack_valid,
   input logic [IDX_W-1:0]          ack_idx,
   input logic                      eoi_valid,
   input logic [IDX_W-1:0]          eoi_idx,
   input logic [NUM_SRC-1:0]        req,
   input logic [NUM_SRC-1:0]        pend_q,
   input logic [NUM_SRC-1:0]        insvc_q,
   input logic [NUM_SRC-1:0]        mask_q,
   input logic [NUM_SRC*LOCK_W-1:0] lock_q
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
      // R4: a request needs a pending, unmasked source
      p_req_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
         req[i] |-> (pend_q[i] && !mask_q[i]));

      // R8: acknowledge of a pending source puts it in service
      p_ack_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_valid && ack_idx == IDX_W'(i) && pend_q[i]) |=> insvc_q[i]);

      // R8: in-service only begins after an acknowledge naming it
      p_insvc_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(insvc_q[i]) |-> $past(ack_valid && ack_idx == IDX_W'(i)));

      // R9: end-of-interrupt releases service
      p_eoi_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (eoi_valid && eoi_idx == IDX_W'(i) &&
          !(ack_valid && ack_idx == IDX_W'(i) && pend_q[i])) |=> !insvc_q[i]);

      // R11: locked fields hold while active
      p_lock_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_q[i] || insvc_q[i]) |=> $stable(lock_q[i*LOCK_W +: LOCK_W]));
   end
endmodule

bind ext_irq_cond eic_chk #(
   .NUM_SRC (NUM_SRC),
   .IDX_W   (IDX_W),
   .LOCK_W  (LOCK_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ack_valid (ack_valid),
   .ack_idx   (ack_idx),
   .eoi_valid (eoi_valid),
   .eoi_idx   (eoi_idx),
   .req       (req),
   .pend_q    (pend_q),
   .insvc_q   (insvc_q),
   .mask_q    (mask_q),
   .lock_q    (lock_q)
);

// File: tb/sim_ext_irq_cond.sv
`timescale 1ns/1ps
module sim_ext_irq_cond;
   localparam int NS = 12;
   localparam int PW = 4;
   localparam int VW = 16;
   localparam int SS = 2;
   localparam int AW = 9;
   localparam int IW = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NS-1:0]   irq_pin = '1;
   logic            cfg_wr = 1'b0;
   logic [AW-1:0]   cfg_addr = '0;
   logic [31:0]     cfg_wdata = '0;
   logic [31:0]     cfg_rdata;
   logic            ack_valid = 1'b0;
   logic [IW-1:0]   ack_idx = '0;
   logic            eoi_valid = 1'b0;
   logic [IW-1:0]   eoi_idx = '0;
   logic [NS-1:0]   req;
   logic [NS*PW-1:0] req_prio;
   logic [NS*VW-1:0] req_vec;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   ext_irq_cond #(.NUM_SRC(NS), .PRIO_W(PW), .VEC_W(VW),
                  .SYNC_STAGES(SS), .ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .cfg_wr(cfg_wr),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .ack_valid(ack_valid), .ack_idx(ack_idx), .eoi_valid(eoi_valid),
      .eoi_idx(eoi_idx), .req(req), .req_prio(req_prio), .req_vec(req_vec));

   // behavioural reference state
   bit [SS-1:0] m_sy   [NS];
   bit          m_prev [NS];
   bit          m_pend [NS];
   bit          m_ins  [NS];
   bit          m_mask [NS];
   bit          m_pol  [NS];
   bit          m_sen  [NS];
   bit [PW-1:0] m_prio [NS];
   bit [VW-1:0] m_vec  [NS];

   task automatic model_reset();
      for (int i = 0; i < NS; i++) begin
         m_sy[i] = '0; m_prev[i] = 0; m_pend[i] = 0; m_ins[i] = 0;
         m_mask[i] = 1; m_pol[i] = 0; m_sen[i] = 0; m_prio[i] = '0; m_vec[i] = '0;
      end
   endtask

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         for (int i = 0; i < NS; i++) begin
            bit s, on, was, edg, ackh, eoih, act;
            s    = m_sy[i][SS-1];
            on   = m_pol[i] ? s : !s;
            was  = m_pol[i] ? m_prev[i] : !m_prev[i];
            edg  = on && !was;
            ackh = ack_valid && (int'(ack_idx) == i) && m_pend[i];
            eoih = eoi_valid && (int'(eoi_idx) == i);
            act  = m_pend[i] || m_ins[i];
            if (m_sen[i]) m_pend[i] = on && !ackh && !m_ins[i];
            else          m_pend[i] = (m_pend[i] && !ackh) || edg;
            m_ins[i] = ackh || (m_ins[i] && !eoih);
            if (cfg_wr && cfg_addr[4:0] == 5'd0 && int'(cfg_addr[AW-1:5]) == i) begin
               m_mask[i] = cfg_wdata[31];
               if (!act) begin
                  m_pol[i]  = cfg_wdata[23];
                  m_sen[i]  = cfg_wdata[22];
                  m_prio[i] = cfg_wdata[19:16];
                  m_vec[i]  = cfg_wdata[15:0];
               end
            end
            m_prev[i] = s;
            m_sy[i]   = {m_sy[i][SS-2:0], irq_pin[i]};
         end
      end
   end

   function automatic logic [31:0] exp_rd(logic [AW-1:0] a);
      int n;
      logic [31:0] w;
      n = int'(a[AW-1:5]);
      w = '0;
      if (a[4:0] == 5'd0 && n < NS) begin
         w[31] = m_mask[n]; w[30] = m_pend[n] | m_ins[n];
         w[23] = m_pol[n];  w[22] = m_sen[n];
         w[19:16] = m_prio[n]; w[15:0] = m_vec[n];
      end
      return w;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [NS-1:0] er;
         for (int i = 0; i < NS; i++) begin
            er[i] = m_pend[i] & ~m_mask[i];
            chk("R4 prio", 32'(req_prio[i*PW +: PW]), 32'(m_prio[i]));
            chk("R4 vec",  32'(req_vec[i*VW +: VW]),  32'(m_vec[i]));
         end
         chk("R4/R6/R7 req", 32'(req), 32'(er));
         chk("R1/R2/R10 rdata", cfg_rdata, exp_rd(cfg_addr));
      end
   end

   task automatic cyc(int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wr(logic [AW-1:0] a, logic [31:0] d);
      cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
      cyc(1);
      cfg_wr = 1'b0;
   endtask

   task automatic rd_chk(string tag, logic [AW-1:0] a, logic [31:0] exp);
      cfg_addr = a;
      @(negedge clk);
      chk(tag, cfg_rdata, exp);
      cyc(1);
   endtask

   task automatic ack(int idx);
      ack_idx = IW'(idx); ack_valid = 1'b1;
      cyc(1);
      ack_valid = 1'b0;
   endtask

   task automatic eoi(int idx);
      eoi_idx = IW'(idx); eoi_valid = 1'b1;
      cyc(1);
      eoi_valid = 1'b0;
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      rd_chk("R3 reset word", 9'h000, 32'h8000_0000);
      rd_chk("R3 reset word last", 9'h160, 32'h8000_0000);
      @(negedge clk); chk("R3 no req", 32'(req), 32'h0);
      cyc(1);

      // R2: all-ones write exposes only defined fields
      wr(9'h0A0, 32'hFFFF_FFFF);
      rd_chk("R2 field layout", 9'h0A0, 32'h80CF_FFFF);
      // R1: unaligned and out-of-range accesses
      wr(9'h004, 32'h0000_0000);
      rd_chk("R1 unaligned read", 9'h004, 32'h0);
      rd_chk("R1 unaligned write ignored", 9'h000, 32'h8000_0000);
      wr(9'h180, 32'h0000_0000);
      rd_chk("R1 slot out of range", 9'h180, 32'h0);

      // configure: src0 rising edge, src1 falling edge, src2 high level, src3 low level
      wr(9'h000, 32'h0085_1234);
      wr(9'h020, 32'h0002_0055);
      wr(9'h040, 32'h00C3_00AA);
      wr(9'h060, 32'h0044_00BB);
      rd_chk("R2 src0 readback", 9'h000, 32'h0085_1234);

      // R5 latency and R6 rising edge
      irq_pin[0] = 1'b0; cyc(4);
      irq_pin[0] = 1'b1;
      cyc(2); @(negedge clk); chk("R5 not yet pending", 32'(req[0]), 32'h0);
      cyc(1); @(negedge clk); chk("R6 rising edge pends", 32'(req[0]), 32'h1);
      rd_chk("R10 activity set", 9'h000, 32'h4085_1234);
      // R11: locked fields, mask still writable
      wr(9'h000, 32'h8000_BEEF);
      rd_chk("R11 lock keeps fields", 9'h000, 32'hC085_1234);
      wr(9'h000, 32'h0000_BEEF);
      // R8: ack to pending and to idle source
      ack(0);
      @(negedge clk); chk("R8 ack clears req", 32'(req[0]), 32'h0);
      ack(1);
      rd_chk("R8 ack idle ignored", 9'h020, 32'h0002_0055);
      // R9: re-arm while in service, then release
      irq_pin[0] = 1'b0; cyc(2); irq_pin[0] = 1'b1; cyc(4);
      @(negedge clk); chk("R9 edge re-pends in service", 32'(req[0]), 32'h1);
      ack(0); eoi(0);
      rd_chk("R9 eoi releases", 9'h000, 32'h0085_1234);

      // R6 falling edge on src1
      irq_pin[1] = 1'b0; cyc(4); irq_pin[1] = 1'b1; cyc(4);
      @(negedge clk); chk("R6 falling edge holds", 32'(req[1]), 32'h1);
      ack(1); eoi(1);
      // R7 level on src2
      irq_pin[2] = 1'b1; cyc(4);
      @(negedge clk); chk("R7 level high pends", 32'(req[2]), 32'h1);
      ack(2); cyc(2);
      @(negedge clk); chk("R7 held in service", 32'(req[2]), 32'h0);
      irq_pin[2] = 1'b0; eoi(2); cyc(4);
      @(negedge clk); chk("R7 level gone", 32'(req[2]), 32'h0);

      // random traffic, checked every cycle by the model
      for (int k = 0; k < 4000; k++) begin
         for (int i = 0; i < NS; i++)
            if ($urandom % 16 == 0) irq_pin[i] = ~irq_pin[i];
         ack_valid = ($urandom % 4 == 0); ack_idx = IW'($urandom % 16);
         eoi_valid = ($urandom % 4 == 0); eoi_idx = IW'($urandom % 16);
         cfg_wr    = ($urandom % 16 == 0);
         cfg_addr  = AW'((($urandom % 16) << 5) | (($urandom % 8 == 0) ? 4 : 0));
         cfg_wdata = $urandom;
         cyc(1);
      end
      cfg_wr = 1'b0; ack_valid = 1'b0; eoi_valid = 1'b0;
      cyc(2);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end
endmodule